// File: doc/BRIEF.md
# Two-Way Set-Associative DRAM Line Cache

This block sits between a 32-bit processor bus and a 128-bit DRAM controller port. It holds two ways of cached lines per set, picks the way to replace with one least-recently-used bit per set, and moves whole lines to and from memory in 16-byte beats. With the default parameters it stores 128 KB (2 ways, 256 sets, 256-byte lines) and covers an 8 MB byte address space. The line data lives in an external synchronous single-port SRAM with 128-bit rows and byte write enables. The block keeps only the tags, the valid and dirty bits, the replacement bits and the control.

A processor access that hits is accepted in the cycle it is presented, with no stall. A read returns its word one cycle later. On a miss the processor is held. If the victim line is dirty, it is first copied out to memory beat by beat. The new line is then fetched, and the held access is served in a final respond cycle. At reset the tags are loaded so that way 0 of every set holds tag 0 and way 1 holds tag 1. The lowest 2×capacity/2 bytes (128 KB by default) are therefore resident and clean before any memory traffic.

Top module: `c2w_dram_cache`

## Requirements
- R1: When a request hits, `cpu_ready` is high in the same cycle as `cpu_req`. For a read, `cpu_rvalid` is high in the next cycle, and `cpu_rdata` then holds the addressed word.
- R2: After reset, and with `PRESET`=1, every address below 2·2^(SET_W+OFF_W) hits without any `mem_req`. Its data is taken from SRAM row {way = address tag bit 0, set, beat}.
- R3: On a miss, `cpu_ready` stays low until the line has been fetched. The fetch uses 2^(OFF_W-4) read beats. Their `mem_addr` values (byte address divided by 16) run in ascending order from the start of the line. `mem_addr` stays unchanged while a beat waits for `mem_ack`, and the word returned afterwards is the one from memory.
- R4: When the victim is dirty, all 2^(OFF_W-4) beats of the victim line are written (`mem_we`=1) in ascending order to the victim's own line address. This happens before the first read beat of the fill.
- R5: When the victim is clean, no write beat is issued.
- R6: A write changes only the bytes whose `cpu_be` bit is set, where `cpu_be[i]` covers `cpu_wdata[8i+7:8i]`. The written line becomes dirty, and later reads see the merged word.
- R7: Each set keeps one replacement bit. After reset it names way 0. Every hit and every fill points it at the other way, and a miss replaces the way it names.
- R8: The byte address is split into offset [OFF_W-1:0], set [SET_W+OFF_W-1:OFF_W] and tag above. With the defaults these are [7:0], [15:8] and [22:16]. Within a line, bits [OFF_W-1:4] select the beat and bits [3:2] select the 32-bit lane of `ram_wdata`/`ram_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_be | input | 4 | Byte enables for a write |
| cpu_addr | input | ADDR_W (23) | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | Access accepted this cycle |
| cpu_rvalid | output | 1 | Read word valid |
| cpu_rdata | output | 32 | Read word |
| mem_req | output | 1 | Beat request to the memory controller |
| mem_we | output | 1 | Beat is a write-back |
| mem_addr | output | ADDR_W-4 (19) | Beat address in 16-byte units |
| mem_wdata | output | 128 | Write-back beat data |
| mem_rdata | input | 128 | Fill beat data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat completed |
| ram_en | output | 1 | Data SRAM enable |
| ram_we | output | 16 | Data SRAM byte write enables (0 = read) |
| ram_addr | output | 1+SET_W+OFF_W-4 (13) | Data SRAM row {way, set, beat} |
| ram_wdata | output | 128 | Data SRAM write row |
| ram_rdata | input | 128 | Data SRAM read row, one cycle after a read |

## Verification
The hardest case to reach from the ports is a dirty victim being evicted in a set whose replacement bit was just turned by a hit. This combines write-back ordering, victim choice and data loss in one access. The bench uses a small geometry of four sets, 64-byte lines and an eight-tag space. Random word writes therefore keep most lines dirty, and almost every miss forces a write-back. Directed sequences also touch one way, then miss in the same set, to pin the victim choice. A memory model with random acknowledge delays checks the order and addresses of the beats.

// File: rtl/c2w_pkg.sv
package c2w_pkg;
  typedef enum logic [1:0] {
    ST_LOOKUP  = 2'd0,
    ST_WBACK   = 2'd1,
    ST_FILL    = 2'd2,
    ST_RESPOND = 2'd3
  } c2w_state_e;
endpackage

// File: rtl/c2w_tag_store.sv
module c2w_tag_store #(
  parameter int SET_W  = 8,
  parameter int TAG_W  = 7,
  parameter bit PRESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             touch_en,
  input  logic             touch_way,
  input  logic             dirty_en,
  input  logic             dirty_way,
  input  logic             fill_en,
  input  logic             fill_way,
  output logic             hit,
  output logic             hit_way,
  output logic             victim_way,
  output logic [TAG_W-1:0] victim_tag,
  output logic             victim_dirty
);
  localparam int SETS = 1 << SET_W;

  logic [1:0]            way_hit;
  logic [1:0][TAG_W-1:0] way_tag;
  logic [1:0]            way_dirty;
  logic [SETS-1:0]       lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  drt_q;
    logic             wr_fill;
    logic             wr_dirty;

    assign wr_fill  = fill_en && (fill_way == 1'(w));
    assign wr_dirty = dirty_en && (dirty_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) begin
          tag_q[s] <= PRESET ? TAG_W'(w) : '0;
        end
        vld_q <= PRESET ? '1 : '0;
        drt_q <= '0;
      end else begin
        if (wr_fill) begin
          tag_q[set_idx] <= look_tag;
          vld_q[set_idx] <= 1'b1;
          drt_q[set_idx] <= 1'b0;
        end else if (wr_dirty) begin
          drt_q[set_idx] <= 1'b1;
        end
      end
    end

    assign way_tag[w]   = tag_q[set_idx];
    assign way_hit[w]   = vld_q[set_idx] && (tag_q[set_idx] == look_tag);
    assign way_dirty[w] = vld_q[set_idx] && drt_q[set_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else if (touch_en) begin
      lru_q[set_idx] <= ~touch_way;
    end
  end

  assign hit          = |way_hit;
  assign hit_way      = way_hit[1];
  assign victim_way   = lru_q[set_idx];
  assign victim_tag   = way_tag[victim_way];
  assign victim_dirty = way_dirty[victim_way];

  // R3
  one_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  // R7
  lru_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en && !fill_en |=> lru_q[$past(set_idx)] != $past(touch_way));

  // R6
  dirty_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_en && !fill_en && (touch_way == dirty_way) && touch_en
    |=> ($past(dirty_way) ? g_way[1].drt_q[$past(set_idx)] : g_way[0].drt_q[$past(set_idx)]));
endmodule

// File: rtl/c2w_ctrl.sv
module c2w_ctrl
  import c2w_pkg::*;
#(
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              hit,
  input  logic              victim_dirty,
  input  logic              mem_ack,
  output c2w_state_e        state,
  output logic [BEAT_W-1:0] beat,
  output logic              wb_have,
  output logic              last_beat
);
  c2w_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              have_q, have_d;

  assign last_beat = &beat_q;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    have_d  = have_q;
    unique case (state_q)
      ST_LOOKUP: begin
        beat_d = '0;
        have_d = 1'b0;
        if (cpu_req && !hit) begin
          state_d = victim_dirty ? ST_WBACK : ST_FILL;
        end
      end
      ST_WBACK: begin
        if (!have_q) begin
          have_d = 1'b1;
        end else if (mem_ack) begin
          have_d = 1'b0;
          beat_d = beat_q + 1'b1;
          if (last_beat) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          beat_d = beat_q + 1'b1;
          if (last_beat) state_d = ST_RESPOND;
        end
      end
      ST_RESPOND: begin
        state_d = ST_LOOKUP;
      end
      default: state_d = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOOKUP;
      beat_q  <= '0;
      have_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      have_q  <= have_d;
    end
  end

  assign state   = state_q;
  assign beat    = beat_q;
  assign wb_have = have_q;

  // R4
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WBACK) && have_q && mem_ack && last_beat |=> state_q == ST_FILL);

  // R3
  fill_then_respond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL) && mem_ack && last_beat |=> state_q == ST_RESPOND);
endmodule

// File: rtl/c2w_dram_cache.sv
module c2w_dram_cache
  import c2w_pkg::*;
#(
  parameter int OFF_W  = 8,
  parameter int SET_W  = 8,
  parameter int TAG_W  = 7,
  parameter bit PRESET = 1'b1,
  localparam int ADDR_W = TAG_W + SET_W + OFF_W,
  localparam int BEAT_W = OFF_W - 4,
  localparam int ROW_W  = 1 + SET_W + BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [3:0]        cpu_be,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [31:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-5:0] mem_addr,
  output logic [127:0]      mem_wdata,
  input  logic [127:0]      mem_rdata,
  input  logic              mem_ack,
  output logic              ram_en,
  output logic [15:0]       ram_we,
  output logic [ROW_W-1:0]  ram_addr,
  output logic [127:0]      ram_wdata,
  input  logic [127:0]      ram_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [SET_W-1:0]  a_set;
  logic [TAG_W-1:0]  a_tag;
  logic [BEAT_W-1:0] a_beat;
  logic [1:0]        a_lane;

  assign a_lane = cpu_addr[3:2];
  assign a_beat = cpu_addr[OFF_W-1:4];
  assign a_set  = cpu_addr[OFF_W +: SET_W];
  assign a_tag  = cpu_addr[OFF_W+SET_W +: TAG_W];

  c2w_state_e        state;
  logic [BEAT_W-1:0] beat;
  logic              wb_have, last_beat;
  logic              hit, hit_way, victim_way, victim_dirty;
  logic [TAG_W-1:0]  victim_tag;
  logic              fill_en, touch_en, touch_way;

  assign cpu_ready = ((state == ST_LOOKUP) && cpu_req && hit) || (state == ST_RESPOND);
  assign fill_en   = (state == ST_FILL) && mem_ack && last_beat;
  assign touch_en  = cpu_ready || fill_en;
  assign touch_way = fill_en ? victim_way : hit_way;

  c2w_ctrl #(.BEAT_W(BEAT_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_ni),
    .cpu_req      (cpu_req),
    .hit          (hit),
    .victim_dirty (victim_dirty),
    .mem_ack      (mem_ack),
    .state        (state),
    .beat         (beat),
    .wb_have      (wb_have),
    .last_beat    (last_beat)
  );

  c2w_tag_store #(.SET_W(SET_W), .TAG_W(TAG_W), .PRESET(PRESET)) tags_i (
    .clk          (clk),
    .rst_n        (rst_ni),
    .set_idx      (a_set),
    .look_tag     (a_tag),
    .touch_en     (touch_en),
    .touch_way    (touch_way),
    .dirty_en     (cpu_ready && cpu_we),
    .dirty_way    (hit_way),
    .fill_en      (fill_en),
    .fill_way     (victim_way),
    .hit          (hit),
    .hit_way      (hit_way),
    .victim_way   (victim_way),
    .victim_tag   (victim_tag),
    .victim_dirty (victim_dirty)
  );

  always_comb begin
    ram_en    = 1'b0;
    ram_we    = '0;
    ram_addr  = {hit_way, a_set, a_beat};
    ram_wdata = {4{cpu_wdata}};
    if (cpu_ready) begin
      ram_en = 1'b1;
      if (cpu_we) ram_we = 16'(cpu_be) << {a_lane, 2'b00};
    end else if ((state == ST_WBACK) && !wb_have) begin
      ram_en   = 1'b1;
      ram_addr = {victim_way, a_set, beat};
    end else if ((state == ST_FILL) && mem_ack) begin
      ram_en    = 1'b1;
      ram_we    = '1;
      ram_addr  = {victim_way, a_set, beat};
      ram_wdata = mem_rdata;
    end
  end

  assign mem_req   = ((state == ST_WBACK) && wb_have) || (state == ST_FILL);
  assign mem_we    = (state == ST_WBACK);
  assign mem_addr  = (state == ST_WBACK) ? {victim_tag, a_set, beat} : {a_tag, a_set, beat};
  assign mem_wdata = ram_rdata;

  logic       rd_pend_q;
  logic [1:0] lane_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      lane_q    <= 2'b00;
    end else begin
      rd_pend_q <= cpu_ready && !cpu_we;
      if (cpu_ready) lane_q <= a_lane;
    end
  end

  assign cpu_rvalid = rd_pend_q;
  assign cpu_rdata  = ram_rdata[{lane_q, 5'b00000} +: 32];

  // R1
  read_returns_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cpu_ready && !cpu_we |=> cpu_rvalid);

  // R3
  stall_during_mem_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req |-> !cpu_ready);

  // R3
  beat_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req && !mem_ack |=> $stable(mem_addr));
endmodule

// File: tb/c2w_dram_cache_tb_top.sv
module c2w_dram_cache_tb_top;
  localparam int OFF_W = 6, SET_W = 2, TAG_W = 3;
  localparam int AW = TAG_W + SET_W + OFF_W;
  localparam int ROW_W = 1 + SET_W + OFF_W - 4;
  localparam int BEATS = 1 << (OFF_W - 4);
  localparam int WORDS = 1 << (AW - 2);

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic cpu_req, cpu_we, cpu_ready, cpu_rvalid;
  logic [3:0] cpu_be;
  logic [AW-1:0] cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [AW-5:0] mem_addr;
  logic [127:0] mem_wdata, mem_rdata;
  logic ram_en;
  logic [15:0] ram_we;
  logic [ROW_W-1:0] ram_addr;
  logic [127:0] ram_wdata, ram_rdata;

  c2w_dram_cache #(.OFF_W(OFF_W), .SET_W(SET_W), .TAG_W(TAG_W), .PRESET(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata));

  logic [127:0] sram [1 << ROW_W];
  logic [127:0] dram [WORDS / 4];
  logic [31:0]  ref_mem [WORDS];
  logic [TAG_W-1:0] r_tag [1 << SET_W][2];
  logic r_dirty [1 << SET_W][2];
  logic r_lru [1 << SET_W];

  int total = 0, bad = 0;
  int wr_beats, rd_beats, addr_err, order_err;
  logic saw_rd;
  logic [AW-5:0] exp_wb_base, exp_fill_base;

  function automatic logic [31:0] pat(input int w);
    return (32'(w) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = n[8*i +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // data SRAM model: one-cycle read, byte writes, output held otherwise
  always @(posedge clk) begin
    if (ram_en) begin
      for (int b = 0; b < 16; b++)
        if (ram_we[b]) sram[ram_addr][8*b +: 8] <= ram_wdata[8*b +: 8];
      if (ram_we == 16'h0) ram_rdata <= sram[ram_addr];
    end
  end

  // memory controller model with random acknowledge delay
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req && ($urandom % 3 != 0)) begin
      if (mem_we) begin
        if (saw_rd) order_err++;
        if (mem_addr != exp_wb_base + (AW-4)'(wr_beats)) addr_err++;
        dram[mem_addr] = mem_wdata;
        wr_beats++;
      end else begin
        saw_rd = 1'b1;
        if (mem_addr != exp_fill_base + (AW-4)'(rd_beats)) addr_err++;
        mem_rdata = dram[mem_addr];
        rd_beats++;
      end
      mem_ack = 1'b1;
    end
  end

  task automatic access(input logic we, input logic [3:0] be, input logic [AW-1:0] addr,
                        input logic [31:0] wd);
    int s = int'(addr[OFF_W +: SET_W]);
    logic [TAG_W-1:0] t = addr[OFF_W+SET_W +: TAG_W];
    int word = int'(addr[AW-1:2]);
    bit exp_hit, exp_wb, way, done;
    int stall = 0;
    // R8 field split used for the expected hit/miss
    exp_hit = (r_tag[s][0] == t) || (r_tag[s][1] == t);
    way = exp_hit ? (r_tag[s][1] == t) : r_lru[s];
    exp_wb = !exp_hit && r_dirty[s][way];
    exp_wb_base = {r_tag[s][way], SET_W'(s), (OFF_W-4)'(0)};
    exp_fill_base = {t, SET_W'(s), (OFF_W-4)'(0)};
    wr_beats = 0; rd_beats = 0; addr_err = 0; order_err = 0; saw_rd = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_be = be; cpu_addr = addr; cpu_wdata = wd;
    done = 1'b0;
    while (!done) begin
      #5;
      if (cpu_ready) done = 1'b1;
      else begin
        stall++;
        if (stall > 400) break;
        @(negedge clk);
      end
    end
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    // R1 / R3: stall only on a miss
    chk(done && ((stall == 0) == exp_hit), "R1/R3 stall-vs-hit", 32'(stall), 32'(!exp_hit));
    // R3 / R7: fill beat count follows the LRU-chosen victim
    chk(rd_beats == (exp_hit ? 0 : BEATS), "R3/R7 fill beats", 32'(rd_beats),
        32'(exp_hit ? 0 : BEATS));
    // R4 / R5: write-back only for a dirty victim
    chk(wr_beats == (exp_wb ? BEATS : 0), exp_wb ? "R4 writeback beats" : "R5 clean victim",
        32'(wr_beats), 32'(exp_wb ? BEATS : 0));
    chk(addr_err == 0 && order_err == 0, "R4/R3 beat order and address",
        32'(addr_err + order_err), 32'd0);
    if (!we) begin
      chk(cpu_rvalid == 1'b1, "R1 rvalid", 32'(cpu_rvalid), 32'd1);
      chk(cpu_rdata == ref_mem[word], "R1/R6 read data", cpu_rdata, ref_mem[word]);
    end
    if (!exp_hit) begin
      r_tag[s][way] = t;
      r_dirty[s][way] = 1'b0;
    end
    r_lru[s] = ~way;
    if (we) begin
      ref_mem[word] = merge(ref_mem[word], wd, be);
      r_dirty[s][way] = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int w = 0; w < WORDS; w++) ref_mem[w] = pat(w);
    for (int r = 0; r < WORDS / 4; r++)
      dram[r] = {pat(4*r+3), pat(4*r+2), pat(4*r+1), pat(4*r)};
    // R2 preset: row {way,set,beat} mirrors tag=way of the low region
    for (int r = 0; r < (1 << ROW_W); r++)
      sram[r] = {pat(4*r+3), pat(4*r+2), pat(4*r+1), pat(4*r)};
    for (int s = 0; s < (1 << SET_W); s++) begin
      r_tag[s][0] = '0; r_tag[s][1] = TAG_W'(1);
      r_dirty[s][0] = 1'b0; r_dirty[s][1] = 1'b0; r_lru[s] = 1'b0;
    end
    ram_rdata = '0; mem_rdata = '0; mem_ack = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_be = 4'h0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(!cpu_ready && !cpu_rvalid && !mem_req, "R2 reset outputs",
        {29'd0, cpu_ready, cpu_rvalid, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: low region resident, both ways
    access(1'b0, 4'h0, 11'h000, 32'h0);
    access(1'b0, 4'h0, 11'h1FC, 32'h0);
    access(1'b0, 4'h0, 11'h0C8, 32'h0);
    access(1'b0, 4'h0, 11'h134, 32'h0);
    // R6: partial byte writes then readback
    access(1'b1, 4'b0101, 11'h044, 32'hDEADBEEF);
    access(1'b0, 4'h0, 11'h044, 32'h0);
    access(1'b1, 4'b1000, 11'h048, 32'h11223344);
    access(1'b0, 4'h0, 11'h048, 32'h0);
    // R7: set 1, touch way0 (tag0) then miss evicts way1 (tag1)
    access(1'b0, 4'h0, 11'h040, 32'h0);
    access(1'b0, 4'h0, 11'h240, 32'h0);
    access(1'b0, 4'h0, 11'h04C, 32'h0);
    access(1'b0, 4'h0, 11'h140, 32'h0);
    // R4: dirty lines in set 2 forced out, then read back from memory
    access(1'b1, 4'hF, 11'h380, 32'hCAFEF00D);
    access(1'b1, 4'hF, 11'h4BC, 32'h0BADC0DE);
    access(1'b0, 4'h0, 11'h580, 32'h0);
    access(1'b0, 4'h0, 11'h680, 32'h0);
    access(1'b0, 4'h0, 11'h380, 32'h0);
    access(1'b0, 4'h0, 11'h4BC, 32'h0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a = {9'($urandom % WORDS), 2'b00};
      logic [3:0] be = 4'($urandom);
      if (be == 4'h0) be = 4'h1;
      access(1'($urandom), be, a, $urandom);
    end
    // final sweep: every word matches the reference (R3/R4/R6)
    for (int w = 0; w < WORDS; w += 7) access(1'b0, 4'h0, {9'(w), 2'b00}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule